// File: doc/BRIEF.md
# Next-PC Unit with Delay Slot

This block owns the program counter of a 32-bit five-stage pipeline whose branches resolve in the decode stage and carry a single architectural delay slot. Each cycle it picks the next fetch address from three candidates: the sequential address, a PC-relative branch target, and a region-relative jump target. Which one it picks depends on the instruction sitting in decode and its already-forwarded register operands.

When decode holds a branch or jump, fetch is already holding the instruction that follows it, and that instruction always runs. Branch and jump targets are therefore formed from the fetch PC, which is the address of the delay-slot instruction. The redirect takes effect on the fetch after the slot. Hazard logic and the instruction cache stall fetch through one enable. That enable freezes the PC and is passed on as the instruction-register write-enable, so a branch held in decode is evaluated again on the cycle the stall lifts.

Top module: `npc_unit`

## Requirements
- R1: While the active-low reset `rst_n` is asserted, `pc` reads 0. After release, the first fetch address is 0.
- R2: With `fetch_en` high and no redirect, `pc` advances by exactly 4 at each rising clock edge.
- R3: A taken branch with `fetch_en` high loads `pc` with the current `pc` plus `dec_instr[15:0]`, sign-extended and multiplied by 4.
- R4: `cond_sel` selects the branch condition. 2'b00 tests `opnd_a == opnd_b`. 2'b01 tests `opnd_a == 0`. 2'b10 tests `opnd_a` negative, meaning bit 31 is set. 2'b11 is never taken.
- R5: With `is_jump` and `fetch_en` high, `pc` becomes {current `pc[31:28]`, `dec_instr[25:0]`, 2'b00}. A jump takes priority over a simultaneous taken branch.
- R6: With `fetch_en` low, `pc` holds its value whatever the branch and jump inputs are. A stall beats a taken branch, and the branch takes effect on the first enabled cycle afterwards.
- R7: `ir_we` equals `fetch_en` in the same cycle.
- R8: With `is_branch` low, or with a branch whose condition is false, the operands and offset have no effect and `pc` advances by 4.
- R9: Address arithmetic wraps modulo 2^32, for both sequential steps and negative branch offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_en | input | 1 | PC/IR write-enable; low for bubbles and cache misses |
| dec_instr | input | 32 | Instruction word in decode (offset in [15:0], jump index in [25:0]) |
| opnd_a | input | 32 | First source operand after forwarding |
| opnd_b | input | 32 | Second source operand after forwarding |
| is_branch | input | 1 | Decode holds a conditional branch |
| is_jump | input | 1 | Decode holds an unconditional jump |
| cond_sel | input | 2 | Branch condition select (see R4) |
| pc | output | 32 | Registered fetch address |
| ir_we | output | 1 | Instruction-register write-enable |

## Verification
The assertions check on every cycle that a stall freezes the PC, that an unredirected enabled cycle steps by 4, that the distance moved by a taken branch matches the sign-extended offset, and that a jump keeps the top four PC bits and lands word-aligned. They also check that the condition evaluator never reports taken without a branch or with the reserved selector, and that a negative operand under the sign test is always taken. Only the bench scenarios can show the absolute addresses reached: the reset address, wrap-around past zero in both directions, jump-over-branch priority, and a branch that waits through a stall and then redirects.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Branch condition selector; encoding is decoded by npc_cond
  typedef enum logic [1:0] {
    COND_EQ   = 2'b00,
    COND_EQZ  = 2'b01,
    COND_LTZ  = 2'b10,
    COND_NONE = 2'b11
  } cond_e;

  // Which candidate feeds the PC register
  typedef enum logic [1:0] {
    SRC_SEQ = 2'b00,
    SRC_BR  = 2'b01,
    SRC_JMP = 2'b10
  } pc_src_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_branch,
  input  logic [1:0]        cond_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              take
);

  localparam int SIGN_BIT = DATA_W - 1;

  cond_e sel;
  logic  cond_met;

  function automatic logic eval_cond(input cond_e c,
                                     input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b);
    logic r;
    unique case (c)
      COND_EQ:   r = (a == b);
      COND_EQZ:  r = (a == '0);
      COND_LTZ:  r = a[SIGN_BIT];
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  always_comb begin
    sel      = cond_e'(cond_sel);
    cond_met = eval_cond(sel, opnd_a, opnd_b);
    take     = is_branch & cond_met;
  end

  // R8
  no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |-> !take);

  // R4
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 2'b11) |-> !take);

  // R4
  ltz_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && cond_sel == 2'b10 && opnd_a[SIGN_BIT]) |-> take);

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_W     = 32,
  parameter int OFF_W      = 16,
  parameter int JIDX_W     = 26,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [INSN_W-1:0] instr,
  input  logic              br_take,
  input  logic              is_jump,
  output logic [ADDR_W-1:0] next_pc,
  output logic              redirect,
  output pc_src_e           src
);

  localparam int SH     = $clog2(INSN_BYTES);
  localparam int EXT_W  = ADDR_W - OFF_W - SH;
  localparam int HI_W   = ADDR_W - JIDX_W - SH;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  // Sequential successor of the fetch address
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] p);
    return p + STEP;
  endfunction

  // Sign-extended, word-scaled branch displacement
  function automatic logic [ADDR_W-1:0] br_disp(input logic [OFF_W-1:0] f);
    return {{EXT_W{f[OFF_W-1]}}, f, {SH{1'b0}}};
  endfunction

  // PC-relative target based on the delay-slot address
  function automatic logic [ADDR_W-1:0] br_addr(input logic [ADDR_W-1:0] p,
                                                input logic [OFF_W-1:0] f);
    return p + br_disp(f);
  endfunction

  // Region-relative target: upper bits kept from the fetch address
  function automatic logic [ADDR_W-1:0] jmp_addr(input logic [ADDR_W-1:0] p,
                                                 input logic [JIDX_W-1:0] idx);
    return {p[ADDR_W-1 -: HI_W], idx, {SH{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] cand_seq;
  logic [ADDR_W-1:0] cand_br;
  logic [ADDR_W-1:0] cand_jmp;

  always_comb begin
    cand_seq = seq_addr(fetch_pc);
    cand_br  = br_addr(fetch_pc, instr[OFF_W-1:0]);
    cand_jmp = jmp_addr(fetch_pc, instr[JIDX_W-1:0]);
  end

  // Jump outranks a branch decided in the same cycle
  always_comb begin
    if (is_jump)      src = SRC_JMP;
    else if (br_take) src = SRC_BR;
    else              src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JMP: next_pc = cand_jmp;
      SRC_BR:  next_pc = cand_br;
      default: next_pc = cand_seq;
    endcase
    redirect = (src != SRC_SEQ);
  end

endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
  parameter int               ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_PC;
    else if (we) q <= d;
  end

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_W     = 32,
  parameter int OFF_W      = 16,
  parameter int JIDX_W     = 26,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en,
  input  logic [INSN_W-1:0] dec_instr,
  input  logic [ADDR_W-1:0] opnd_a,
  input  logic [ADDR_W-1:0] opnd_b,
  input  logic              is_branch,
  input  logic              is_jump,
  input  logic [1:0]        cond_sel,
  output logic [ADDR_W-1:0] pc,
  output logic              ir_we
);

  localparam int SH    = $clog2(INSN_BYTES);
  localparam int EXT_W = ADDR_W - OFF_W - SH;
  localparam int HI_W  = ADDR_W - JIDX_W - SH;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  // Named internal events for the checks
  logic              br_take;
  logic              redirect;
  logic [ADDR_W-1:0] next_pc;
  pc_src_e           src;

  npc_cond #(.DATA_W(ADDR_W)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_branch (is_branch),
    .cond_sel  (cond_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .take      (br_take)
  );

  npc_target #(
    .ADDR_W     (ADDR_W),
    .INSN_W     (INSN_W),
    .OFF_W      (OFF_W),
    .JIDX_W     (JIDX_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_target (
    .fetch_pc (pc),
    .instr    (dec_instr),
    .br_take  (br_take),
    .is_jump  (is_jump),
    .next_pc  (next_pc),
    .redirect (redirect),
    .src      (src)
  );

  npc_pcreg #(.ADDR_W(ADDR_W), .RESET_PC('0)) u_pcreg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fetch_en),
    .d     (next_pc),
    .q     (pc)
  );

  // The same enable gates the instruction register
  assign ir_we = fetch_en;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !redirect) |=> (pc == $past(pc) + STEP));

  // R3
  br_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && br_take && !is_jump) |=>
      ((pc - $past(pc)) ==
       {{EXT_W{$past(dec_instr[OFF_W-1])}}, $past(dec_instr[OFF_W-1:0]), {SH{1'b0}}}));

  // R5
  jmp_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && is_jump) |=>
      ((pc[ADDR_W-1 -: HI_W] == $past(pc[ADDR_W-1 -: HI_W])) && (pc[SH-1:0] == '0)));

  // R5
  jmp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |-> (src == SRC_JMP));

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_en;
  logic [31:0] dec_instr;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic        is_branch;
  logic        is_jump;
  logic [1:0]  cond_sel;
  logic [31:0] pc;
  logic        ir_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  npc_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_en  (fetch_en),
    .dec_instr (dec_instr),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .is_branch (is_branch),
    .is_jump   (is_jump),
    .cond_sel  (cond_sel),
    .pc        (pc),
    .ir_we     (ir_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        en;
    logic        br;
    logic        jp;
    logic [1:0]  cs;
    logic [31:0] ins;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp_pc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  // Walked from pc = 0 after reset; exp_pc is the address after the edge
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0000, 32'd0, 32'd0, 32'h0000_0004, 4'd2},       // R2
    '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0000, 32'd0, 32'd0, 32'h0000_0008, 4'd2},       // R2
    '{1'b1, 1'b1, 1'b0, 2'b00, 32'h10A5_0003, 32'd5, 32'd5, 32'h0000_0014, 4'd3},       // R3 eq taken
    '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0000, 32'd0, 32'd0, 32'h0000_0018, 4'd2},       // R2
    '{1'b1, 1'b1, 1'b0, 2'b00, 32'h10A5_0003, 32'd1, 32'd2, 32'h0000_001C, 4'd8},       // R8 eq not taken
    '{1'b1, 1'b1, 1'b0, 2'b01, 32'h1040_FFFE, 32'd0, 32'd9, 32'h0000_0014, 4'd3},       // R3 negative offset
    '{1'b1, 1'b1, 1'b0, 2'b01, 32'h1040_FFFE, 32'd7, 32'd0, 32'h0000_0018, 4'd4},       // R4 eqz false
    '{1'b1, 1'b1, 1'b0, 2'b10, 32'h0400_0010, 32'h8000_0000, 32'd0, 32'h0000_0058, 4'd4}, // R4 ltz true
    '{1'b1, 1'b1, 1'b0, 2'b10, 32'h0400_0010, 32'h7FFF_FFFF, 32'd0, 32'h0000_005C, 4'd4}, // R4 ltz false
    '{1'b0, 1'b1, 1'b0, 2'b00, 32'h1000_0004, 32'd3, 32'd3, 32'h0000_005C, 4'd6},       // R6 stall beats branch
    '{1'b1, 1'b1, 1'b0, 2'b00, 32'h1000_0004, 32'd3, 32'd3, 32'h0000_006C, 4'd6},       // R6 branch after stall
    '{1'b1, 1'b1, 1'b1, 2'b00, 32'h0800_0040, 32'd3, 32'd3, 32'h0000_0100, 4'd5},       // R5 jump over branch
    '{1'b1, 1'b0, 1'b0, 2'b00, 32'h0000_0003, 32'd6, 32'd6, 32'h0000_0104, 4'd8},       // R8 no branch flag
    '{1'b1, 1'b1, 1'b0, 2'b11, 32'h0000_0003, 32'd6, 32'd6, 32'h0000_0108, 4'd4},       // R4 reserved select
    '{1'b0, 1'b0, 1'b1, 2'b00, 32'h0800_0000, 32'd0, 32'd0, 32'h0000_0108, 4'd6},       // R6 stall beats jump
    '{1'b1, 1'b0, 1'b1, 2'b00, 32'h0800_0000, 32'd0, 32'd0, 32'h0000_0000, 4'd5}        // R5 jump to zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, check ir_we there, then check pc just after the rising edge
  task automatic step(input logic en, input logic br, input logic jp, input logic [1:0] cs,
                      input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] exp_pc, input string req);
    @(negedge clk);
    fetch_en  = en;
    is_branch = br;
    is_jump   = jp;
    cond_sel  = cs;
    dec_instr = ins;
    opnd_a    = a;
    opnd_b    = b;
    #1;
    check("R7", {31'd0, ir_we}, {31'd0, en});
    @(posedge clk);
    #1;
    check(req, pc, exp_pc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    fetch_en = 1'b0;
    #1;
    check("R1", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    fetch_en  = 1'b0;
    is_branch = 1'b0;
    is_jump   = 1'b0;
    cond_sel  = 2'b00;
    dec_instr = '0;
    opnd_a    = '0;
    opnd_b    = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].en, VECS[i].br, VECS[i].jp, VECS[i].cs, VECS[i].ins,
           VECS[i].a, VECS[i].b, VECS[i].exp_pc, $sformatf("R%0d", VECS[i].req));
    end

    // R1: reset mid-run returns the PC to zero
    step(1'b1, 1'b0, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 32'h0000_0004, "R2");
    do_reset();

    // R9: negative branch from address 0 wraps to the top, then steps past zero
    step(1'b1, 1'b1, 1'b0, 2'b01, 32'h1000_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFC, "R9");
    step(1'b1, 1'b0, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 32'h0000_0000, "R9");

    // R5: jump keeps the fetch PC's top four bits
    step(1'b1, 1'b1, 1'b0, 2'b01, 32'h1000_FFFC, 32'h0, 32'h0, 32'hFFFF_FFF0, "R3");
    step(1'b1, 1'b0, 1'b1, 2'b00, 32'h0800_0010, 32'h0, 32'h0, 32'hF000_0040, "R5");
    step(1'b1, 1'b0, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 32'hF000_0044, "R2");

    // R6: several stalled cycles with a pending taken branch
    step(1'b0, 1'b1, 1'b0, 2'b00, 32'h1000_0002, 32'd1, 32'd1, 32'hF000_0044, "R6");
    step(1'b0, 1'b1, 1'b0, 2'b00, 32'h1000_0002, 32'd1, 32'd1, 32'hF000_0044, "R6");
    step(1'b1, 1'b1, 1'b0, 2'b00, 32'h1000_0002, 32'd1, 32'd1, 32'hF000_004C, "R3");

    do_reset();
    @(posedge clk);
    #1;
    check("R1", pc, 32'h0);

    finish_run();
  end

endmodule